// File: doc/BRIEF.md
# Static Icon Segment Driver

This block drives a small set of always-on icon segments that share one common electrode. Every icon owns two register bits: one turns it on, the other makes it blink. Software sets these bits through a simple write port at four fixed addresses, with icons split into two banks of five. The block divides the system clock into a slow frame toggle that alternates the common electrode, and further into a blink period of roughly one to two hertz. A lit segment is driven opposite to the common and a dark segment in phase with it, so each icon sees zero average voltage when off.

The block follows the display controller's power modes. In standby (power save asserted with the oscillator running) the icons keep working. With the oscillator disabled all timing freezes and every output sits at the idle level. A sleep-entry request, taken only while power save is on and the oscillator is off, clears all icon registers.

Top module: `icon_drive_ctrl`

## Requirements
- R1: After reset all display and blink bits are zero; once the oscillator is enabled, `com_out` starts low and every segment equals `com_out`.
- R2: A write to address 0x20 loads display bits of icons 0..4 and 0x21 their blink bits; 0x22 and 0x23 do the same for icons 5..9. Within a bank, data bit 4 maps to the first icon of the bank and data bit 0 to the fifth. The new value acts from the cycle after the write strobe.
- R3: Writes to any other address, and data bits 7..5, change no icon state.
- R4: While the oscillator is enabled, `com_out` toggles once every FRAME_DIV clock cycles.
- R5: A lit icon's segment is the inverse of `com_out`; a dark icon's segment equals `com_out`. An icon whose display bit is 0 is dark regardless of its blink bit.
- R6: An icon with display and blink bits both 1 is lit during the first BLINK_HALF common half-periods of each blink period of 2*BLINK_HALF common half-periods, and dark during the rest, counted from reset.
- R7: Power save with the oscillator running has no effect on the outputs.
- R8: While `osc_en` is low, `com_out` and all segments are 0 and the frame and blink timing are frozen; timing resumes from the frozen point when `osc_en` returns high.
- R9: A `sleep_req` cycle with `pwr_save` high and `osc_en` low clears all display and blink bits, taking priority over a write in the same cycle; `sleep_req` in any other case is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| pwr_save | input | 1 | Power-save mode flag |
| osc_en | input | 1 | Oscillator enable |
| sleep_req | input | 1 | Sleep-entry request |
| seg_out | output | 10 | Icon segment levels, icon 0 in bit 0 |
| com_out | output | 1 | Shared common level |

## Verification
A corrupted display or blink register shows immediately at the next sample as a segment that is in phase with the common when it should be inverted, or the reverse. A frame counter that slips shows as a common toggle at the wrong cycle, and a blink counter that slips moves the lit/dark boundary by whole common half-periods, visible within one blink period. Freezing errors show as a common edge arriving early or late once the oscillator is re-enabled.

// File: rtl/icon_pkg.sv
package icon_pkg;
  localparam int unsigned ADDR_W       = 8;
  localparam int unsigned DATA_W       = 8;
  localparam logic [7:0]  ICON_BASE    = 8'h20;
  localparam int unsigned ICONS_PER_BK = 5;
  localparam int unsigned NUM_BANKS    = 2;
  localparam int unsigned NUM_ICONS    = ICONS_PER_BK * NUM_BANKS;
endpackage

// File: rtl/icon_rst_sync.sv
module icon_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/icon_regs.sv
module icon_regs
  import icon_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 clr,
  output logic [NUM_ICONS-1:0] disp_q,
  output logic [NUM_ICONS-1:0] blink_q
);
  logic [NUM_ICONS-1:0] disp_d, blink_d;
  logic [NUM_BANKS-1:0] hit_disp, hit_blink;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [7:0] DISP_ADDR  = ICON_BASE + 8'(2*b);
    localparam logic [7:0] BLINK_ADDR = ICON_BASE + 8'(2*b + 1);
    assign hit_disp[b]  = wr_en && (wr_addr == DISP_ADDR);
    assign hit_blink[b] = wr_en && (wr_addr == BLINK_ADDR);

    for (genvar j = 0; j < ICONS_PER_BK; j++) begin : g_icon
      localparam int unsigned IDX = b*ICONS_PER_BK + j;
      always_comb begin
        disp_d[IDX]  = disp_q[IDX];
        blink_d[IDX] = blink_q[IDX];
        if (clr) begin
          disp_d[IDX]  = 1'b0;
          blink_d[IDX] = 1'b0;
        end else begin
          if (hit_disp[b])  disp_d[IDX]  = wr_data[ICONS_PER_BK-1-j];
          if (hit_blink[b]) blink_d[IDX] = wr_data[ICONS_PER_BK-1-j];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_q  <= '0;
      blink_q <= '0;
    end else begin
      disp_q  <= disp_d;
      blink_q <= blink_d;
    end
  end

  // R9: a clear request empties every register one cycle later
  a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (disp_q == '0) && (blink_q == '0));

  // R3: a strobe that decodes to no register leaves state alone
  a_r3_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (hit_disp == '0) && (hit_blink == '0)) |=> ($stable(disp_q) && $stable(blink_q)));
endmodule

// File: rtl/icon_timebase.sv
module icon_timebase #(
  parameter int unsigned FRAME_DIV  = 256,
  parameter int unsigned BLINK_HALF = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  output logic phase_q,
  output logic blink_on
);
  localparam int unsigned FW        = (FRAME_DIV > 1) ? $clog2(FRAME_DIV) : 1;
  localparam int unsigned BLINK_LEN = 2 * BLINK_HALF;
  localparam int unsigned BW        = $clog2(BLINK_LEN);
  localparam logic [FW-1:0] FRAME_LAST = FW'(FRAME_DIV - 1);
  localparam logic [BW-1:0] BLINK_LAST = BW'(BLINK_LEN - 1);
  localparam logic [BW-1:0] BLINK_MID  = BW'(BLINK_HALF);

  logic [FW-1:0] frame_q, frame_d;
  logic [BW-1:0] bcnt_q,  bcnt_d;
  logic          phase_d;
  logic          frame_wrap;

  assign frame_wrap = osc_en && (frame_q == FRAME_LAST);

  always_comb begin
    frame_d = frame_q;
    phase_d = phase_q;
    bcnt_d  = bcnt_q;
    if (osc_en) begin
      if (frame_wrap) begin
        frame_d = '0;
        phase_d = ~phase_q;
        bcnt_d  = (bcnt_q == BLINK_LAST) ? '0 : bcnt_q + 1'b1;
      end else begin
        frame_d = frame_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      phase_q <= 1'b0;
      bcnt_q  <= '0;
    end else if (osc_en) begin
      frame_q <= frame_d;
      phase_q <= phase_d;
      bcnt_q  <= bcnt_d;
    end
  end

  assign blink_on = (bcnt_q < BLINK_MID);

  // R8: all timing holds still while the oscillator is off
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> ($stable(frame_q) && $stable(phase_q) && $stable(bcnt_q)));

  // R4: frame counter stays inside its modulus
  a_r4_frame_range: assert property (@(posedge clk) disable iff (!rst_n)
    frame_q <= FRAME_LAST);

  // R6: blink phase only moves on a common toggle
  a_r6_blink_on_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(blink_on) |-> !$stable(phase_q));
endmodule

// File: rtl/icon_drive_ctrl.sv
module icon_drive_ctrl
  import icon_pkg::*;
#(
  parameter int unsigned FRAME_DIV  = 256,
  parameter int unsigned BLINK_HALF = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 pwr_save,
  input  logic                 osc_en,
  input  logic                 sleep_req,
  output logic [NUM_ICONS-1:0] seg_out,
  output logic                 com_out
);
  logic                 rst_n_int;
  logic                 sleep_clr;
  logic [NUM_ICONS-1:0] disp_q, blink_q, lit;
  logic                 phase_q, blink_on;

  icon_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign sleep_clr = sleep_req && pwr_save && !osc_en;

  icon_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .clr     (sleep_clr),
    .disp_q  (disp_q),
    .blink_q (blink_q)
  );

  icon_timebase #(
    .FRAME_DIV  (FRAME_DIV),
    .BLINK_HALF (BLINK_HALF)
  ) u_tb (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .osc_en   (osc_en),
    .phase_q  (phase_q),
    .blink_on (blink_on)
  );

  always_comb begin
    lit     = disp_q & (~blink_q | {NUM_ICONS{blink_on}});
    com_out = osc_en & phase_q;
    seg_out = osc_en ? (lit ^ {NUM_ICONS{phase_q}}) : '0;
  end

  // R5: an icon with display off never differs from the common
  a_r5_dark_in_phase: assert property (@(posedge clk) disable iff (!rst_n_int)
    ((seg_out ^ {NUM_ICONS{com_out}}) & ~disp_q) == '0);

  // R8: idle level everywhere while the oscillator is off
  a_r8_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n_int)
    !osc_en |-> (!com_out && (seg_out == '0)));
endmodule

// File: tb/icon_drive_ctrl_tb.sv
module icon_drive_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FD = 3;
  localparam int BH = 2;
  localparam int N  = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0;
  logic [7:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic pwr_save = 0;
  logic osc_en = 0;
  logic sleep_req = 0;
  logic [N-1:0] seg_out;
  logic com_out;

  int checks = 0;
  int fails  = 0;
  int n_en   = 0;
  logic [N-1:0] m_disp = '0;
  logic [N-1:0] m_blink = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icon_drive_ctrl #(.FRAME_DIV(FD), .BLINK_HALF(BH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwr_save(pwr_save), .osc_en(osc_en),
    .sleep_req(sleep_req), .seg_out(seg_out), .com_out(com_out)
  );

  // enabled-cycle count since reset, from R4/R6/R8
  always @(posedge clk) begin
    if (!rst_n) n_en <= 0;
    else if (osc_en) n_en <= n_en + 1;
  end

  function automatic logic exp_com();
    return osc_en ? logic'((n_en / FD) % 2) : 1'b0;
  endfunction

  function automatic logic [N-1:0] exp_seg();
    logic bon;
    logic [N-1:0] lit;
    bon = ((n_en / FD) % (2*BH)) < BH;
    lit = m_disp & (~m_blink | {N{bon}});
    return osc_en ? (lit ^ {N{exp_com()}}) : '0;
  endfunction

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, expv);
    end
  endtask

  task automatic check_outs(string req);
    check(req, {{(N-1){1'b0}}, com_out}, {{(N-1){1'b0}}, exp_com()});
    check(req, seg_out, exp_seg());
  endtask

  // drive during low phase, commit after the rising edge
  task automatic wr(logic [7:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk);
    for (int b = 0; b < 2; b++)
      for (int j = 0; j < 5; j++) begin
        if (a == 8'h20 + 8'(2*b)) m_disp[b*5+j]  = d[4-j];
        if (a == 8'h21 + 8'(2*b)) m_blink[b*5+j] = d[4-j];
      end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run_check(int cycles, string req);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check_outs(req);
    end
  endtask

  task automatic t_reset();
    rst_n = 0; osc_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R8 idle before osc", seg_out, '0);
    osc_en = 1;
    #1;
    check("R1 reset com low", {{(N-1){1'b0}}, com_out}, '0);
    check("R1 reset segs equal com", seg_out, '0);
  endtask

  task automatic t_write_map();
    wr(8'h20, 8'b000_10001);   // icons 0 and 4
    check_outs("R2 bank0 display bits");
    check("R2 icon0 opposite com", {{(N-1){1'b0}}, seg_out[0] ^ com_out}, 1);
    wr(8'h22, 8'b000_01000);   // icon 6
    check_outs("R2 bank1 display bits");
    check("R2 icon6 opposite com", {{(N-1){1'b0}}, seg_out[6] ^ com_out}, 1);
    run_check(FD*2+1, "R4 com toggles with lit icons");
  endtask

  task automatic t_ignored();
    wr(8'h24, 8'hFF);
    wr(8'h1F, 8'hFF);
    wr(8'h28, 8'hFF);
    check_outs("R3 stray addresses ignored");
    wr(8'h22, 8'b111_01000);   // upper bits ignored
    check_outs("R3 upper data bits ignored");
  endtask

  task automatic t_blink();
    wr(8'h21, 8'b000_10100);   // blink icons 0 and 2 (2 is dark)
    wr(8'h23, 8'b000_01000);   // blink icon 6
    run_check(2*BH*FD*2, "R6 blink lit first half");
    check("R5 display-off blink stays dark", {{(N-1){1'b0}}, seg_out[2] ^ com_out}, 0);
  endtask

  task automatic t_standby();
    pwr_save = 1;
    run_check(FD*4, "R7 standby keeps icons");
    sleep_req = 1;             // osc on: not sleep
    @(negedge clk);
    sleep_req = 0;
    run_check(3, "R9 sleep_req with osc on ignored");
    pwr_save = 0;
  endtask

  task automatic t_freeze();
    logic c0;
    osc_en = 0;
    run_check(7, "R8 outputs idle when osc off");
    osc_en = 1;
    #1;
    c0 = com_out;
    check_outs("R8 resume from frozen point");
    run_check(FD*3, "R8 timing continues after resume");
  endtask

  task automatic t_sleep();
    wr(8'h20, 8'b000_11111);
    sleep_req = 1;             // pwr_save low: ignored
    @(negedge clk);
    sleep_req = 0;
    check_outs("R9 sleep_req without power save ignored");
    osc_en = 0; pwr_save = 1; sleep_req = 1;
    wr_en = 1; wr_addr = 8'h20; wr_data = 8'h1F;  // clear beats write
    @(negedge clk);
    sleep_req = 0; wr_en = 0;
    m_disp = '0; m_blink = '0;
    osc_en = 1; pwr_save = 0;
    #1;
    check("R9 sleep clears, segs equal com", seg_out, {N{com_out}});
    run_check(FD*2, "R9 all icons dark after sleep");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_write_map();
        t_ignored();
        t_blink();
        t_standby();
        t_freeze();
        t_sleep();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule